// File: doc/BRIEF.md
# Serial Converter Register Bank

This block is the register set and frame decoder placed in front of a multichannel sampling converter. A host talks to it over a synchronous serial port. The port has a frame-select line and one data line in each direction, and it is timed by the block clock. Every frame is full duplex and 16 bits long. The host shifts a command word in and, at the same time, the block shifts a read word out.

The two leading bits of each incoming word choose where its 14-bit payload goes:

| Address | Destination |
|---------|-------------|
| 00 | nowhere |
| 01 | test word |
| 10 | calibration set |
| 11 | control word |

Reads work differently. The word returned is chosen by a read-select field held in the control word, and that choice stays in force for every later frame. The calibration set holds one gain word, one offset word and eight DAC words. It is reached through an internal step pointer, which walks one of four sequences picked by a calibration-mode field in the control word. Conversion results come in on a 12-bit input. The busy flag comes in on a 1-bit input.

Top module: `adc_regfile`

## Requirements
- R1: After reset the control, test and calibration words and the step pointer are all zero. The first read therefore returns the conversion result, and reads of the test word, the gain word and the status word (with busy low) return 0x0000, 0x0000 and 0x00C0.
- R2: While `csel` is high, one bit is taken from `sdi` on each rising clock edge, MSB first. Bits 15:14 of the word are the address and bits 13:0 are the payload. The payload takes effect on the edge that samples the sixteenth bit.
- R3: If `csel` falls before sixteen bits have been sampled, no register changes, the control word included.
- R4: A frame with address 00 writes nothing. The test and control words keep their values.
- R5: Address 01 loads the payload into the 14-bit test word. With read select 01, a frame returns the test word with two leading zero bits.
- R6: Address 11 loads the control word. Bits 7:6 of the control word are the read select (00 conversion data, 01 test, 10 calibration, 11 status). Bits 1:0 are the calibration mode. The read select applies to every later frame until the next control write.
- R7: With read select 00, a frame returns four zero bits followed by the 12-bit result. The result is the value of `adc_data` on the last clock edge before the frame starts.
- R8: With read select 11, a frame returns the status word. Bit 15 is `busy`, bits 7:6 are the read select, bits 1:0 are the calibration mode, and every other bit is zero.
- R9: Calibration mode 00 steps through gain, offset and DAC words 0 to 7, then wraps back to gain. Each completed frame that writes the calibration set (address 10), or reads it (read select 10), or both, advances the pointer by exactly one step.
- R10: Calibration mode 01 alternates between gain and offset.
- R11: Calibration mode 10 always reaches the gain word. Mode 11 always reaches the offset word. This holds for reads and for writes.
- R12: Every completed control write returns the step pointer to the start of its sequence.
- R13: Read data leaves on `sdo` MSB first, one bit per clock while `csel` is high. Bits sent after the sixteenth are ignored and do not cause a second write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also times the serial port |
| rst | input | 1 | Synchronous reset, active high |
| csel | input | 1 | Frame select, high for the length of a frame |
| sdi | input | 1 | Serial command data, MSB first |
| sdo | output | 1 | Serial read data, MSB first |
| adc_data | input | 12 | Latest conversion result |
| busy | input | 1 | Converter busy flag reported in the status word |

## Verification
The hardest state to reach from the pins is the step pointer at a late position in the ten-word sequence, or at its wrap point. The pointer cannot be read directly. Its position shows only through which calibration word comes back, and any control write moves it back to the start. The stimulus therefore loads all ten words with distinct values through consecutive address-10 frames. It then issues one control write that selects calibration reads, and after that only address-00 frames, so the pointer advances once per frame. Eleven such reads show the whole order and the wrap. A later control write made in the middle of a walk shows the rewind.

// File: rtl/adcreg_pkg.sv
package adcreg_pkg;

    // Where a 2-bit frame header sends the payload.
    typedef enum logic [1:0] {
        DST_NONE = 2'b00,
        DST_TEST = 2'b01,
        DST_CAL  = 2'b10,
        DST_CTRL = 2'b11
    } dest_e;

    // Which word a frame returns.
    typedef enum logic [1:0] {
        RS_DATA = 2'b00,
        RS_TEST = 2'b01,
        RS_CAL  = 2'b10,
        RS_STAT = 2'b11
    } rdsel_e;

    // How the calibration pointer walks the words.
    typedef enum logic [1:0] {
        CM_ALL  = 2'b00,
        CM_PAIR = 2'b01,
        CM_GAIN = 2'b10,
        CM_OFFS = 2'b11
    } calmode_e;

    // Field positions inside the control word and the status word.
    localparam int RDSEL_LSB  = 6;
    localparam int CALSEL_LSB = 0;

    // Word index inside the calibration set.
    localparam int IDX_GAIN = 0;
    localparam int IDX_OFFS = 1;

    // Number of steps in the walk for a given mode.
    function automatic int unsigned seq_len(calmode_e m, int unsigned n_words);
        case (m)
            CM_ALL:  return n_words;
            CM_PAIR: return 2;
            default: return 1;
        endcase
    endfunction

    // Word index reached at a given step of the walk.
    function automatic int unsigned seq_word(calmode_e m, int unsigned step);
        case (m)
            CM_ALL, CM_PAIR: return step;
            CM_GAIN:         return IDX_GAIN;
            default:         return IDX_OFFS;
        endcase
    endfunction

endpackage

// File: rtl/adcreg_frame_rx.sv
module adcreg_frame_rx #(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 2,
    localparam int PAY_W  = FRAME_W - ADDR_W,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csel,
    input  logic              sdi,
    output logic              commit,
    output logic [ADDR_W-1:0] addr,
    output logic [PAY_W-1:0]  payload
);

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-2:0] shift_q;
    logic [FRAME_W-1:0] word;

    // The word as it stands once the current bit is included.
    assign word    = {shift_q, sdi};
    assign commit  = csel && (bit_cnt == CNT_W'(FRAME_W - 1));
    assign addr    = word[FRAME_W-1 -: ADDR_W];
    assign payload = word[PAY_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else if (!csel) begin
            bit_cnt <= '0;
        end else if (bit_cnt < CNT_W'(FRAME_W)) begin
            // Saturating count: bits after the last one are dropped.
            bit_cnt <= bit_cnt + 1'b1;
            shift_q <= word[FRAME_W-2:0];
        end
    end

endmodule

// File: rtl/adcreg_bank.sv
module adcreg_bank
    import adcreg_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int PAY_W   = 14,
    parameter int N_DAC   = 8,
    localparam int N_WORDS = N_DAC + 2,
    localparam int STEP_W  = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAY_W-1:0]  payload,
    output logic [PAY_W-1:0]  ctrl_q,
    output logic [PAY_W-1:0]  test_q,
    output logic [PAY_W-1:0]  cal_word,
    output logic [STEP_W-1:0] step_q,
    output rdsel_e            rdsel,
    output calmode_e          cmode
);

    logic [PAY_W-1:0]  cal_q [N_WORDS];
    logic [STEP_W-1:0] step_nxt;
    logic [STEP_W-1:0] word_idx;
    dest_e             dest;
    logic              cal_touch;
    int unsigned       inc;

    assign dest  = dest_e'(addr[1:0]);
    assign rdsel = rdsel_e'(ctrl_q[RDSEL_LSB +: 2]);
    assign cmode = calmode_e'(ctrl_q[CALSEL_LSB +: 2]);

    assign word_idx = STEP_W'(seq_word(cmode, 32'(step_q)));
    assign cal_word = cal_q[word_idx];

    // A finished frame that reads or writes the calibration set moves the pointer.
    assign cal_touch = commit && ((dest == DST_CAL) || (rdsel == RS_CAL));

    always_comb begin
        inc      = 32'(step_q) + 1;
        step_nxt = (inc >= seq_len(cmode, N_WORDS)) ? '0 : STEP_W'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            test_q <= '0;
            step_q <= '0;
            for (int k = 0; k < N_WORDS; k++) cal_q[k] <= '0;
        end else if (commit) begin
            case (dest)
                DST_TEST: test_q <= payload;
                DST_CTRL: ctrl_q <= payload;
                DST_CAL:  cal_q[word_idx] <= payload;
                default:  ;
            endcase
            if (dest == DST_CTRL)  step_q <= '0;
            else if (cal_touch)    step_q <= step_nxt;
        end
    end

endmodule

// File: rtl/adcreg_tx.sv
module adcreg_tx
    import adcreg_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 2,
    parameter int RES_W   = 12,
    localparam int PAY_W  = FRAME_W - ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csel,
    input  logic [RES_W-1:0]   adc_data,
    input  logic               busy,
    input  rdsel_e             rdsel,
    input  calmode_e           cmode,
    input  logic [PAY_W-1:0]   test_q,
    input  logic [PAY_W-1:0]   cal_word,
    output logic [FRAME_W-1:0] tx_q,
    output logic               sdo
);

    logic [FRAME_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        case (rdsel)
            RS_DATA: rd_word = {{(FRAME_W-RES_W){1'b0}}, adc_data};
            RS_TEST: rd_word = {{ADDR_W{1'b0}}, test_q};
            RS_CAL:  rd_word = {{ADDR_W{1'b0}}, cal_word};
            default: begin
                rd_word[FRAME_W-1]         = busy;
                rd_word[RDSEL_LSB +: 2]    = rdsel;
                rd_word[CALSEL_LSB +: 2]   = cmode;
            end
        endcase
    end

    // Preload while idle, shift while the frame runs.
    always_ff @(posedge clk) begin
        if (rst)        tx_q <= '0;
        else if (!csel) tx_q <= rd_word;
        else            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end

    assign sdo = tx_q[FRAME_W-1];

endmodule

// File: rtl/adc_regfile.sv
module adc_regfile
    import adcreg_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 2,
    parameter int RES_W   = 12,
    parameter int N_DAC   = 8,
    localparam int PAY_W  = FRAME_W - ADDR_W,
    localparam int STEP_W = $clog2(N_DAC + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csel,
    input  logic             sdi,
    output logic             sdo,
    input  logic [RES_W-1:0] adc_data,
    input  logic             busy
);

    logic               commit;
    logic [ADDR_W-1:0]  addr;
    logic [PAY_W-1:0]   payload;
    logic [PAY_W-1:0]   ctrl_q;
    logic [PAY_W-1:0]   test_q;
    logic [PAY_W-1:0]   cal_word;
    logic [STEP_W-1:0]  step_q;
    logic [FRAME_W-1:0] tx_q;
    rdsel_e             rdsel;
    calmode_e           cmode;

    adcreg_frame_rx #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_rx (
        .clk(clk), .rst(rst), .csel(csel), .sdi(sdi),
        .commit(commit), .addr(addr), .payload(payload)
    );

    adcreg_bank #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .N_DAC(N_DAC)) u_bank (
        .clk(clk), .rst(rst), .commit(commit), .addr(addr), .payload(payload),
        .ctrl_q(ctrl_q), .test_q(test_q), .cal_word(cal_word),
        .step_q(step_q), .rdsel(rdsel), .cmode(cmode)
    );

    adcreg_tx #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .RES_W(RES_W)) u_tx (
        .clk(clk), .rst(rst), .csel(csel), .adc_data(adc_data), .busy(busy),
        .rdsel(rdsel), .cmode(cmode), .test_q(test_q), .cal_word(cal_word),
        .tx_q(tx_q), .sdo(sdo)
    );

endmodule

// File: rtl/adcreg_chk.sv
module adcreg_chk
    import adcreg_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 2,
    parameter int RES_W   = 12,
    parameter int N_DAC   = 8,
    localparam int PAY_W  = FRAME_W - ADDR_W,
    localparam int STEP_W = $clog2(N_DAC + 2)
) (
    input logic               clk,
    input logic               rst,
    input logic               csel,
    input logic               commit,
    input logic [ADDR_W-1:0]  addr,
    input logic [PAY_W-1:0]   ctrl_q,
    input logic [PAY_W-1:0]   test_q,
    input logic [STEP_W-1:0]  step_q,
    input logic [FRAME_W-1:0] tx_q,
    input rdsel_e             rdsel,
    input calmode_e           cmode
);

    assert_step_in_walk_R9: assert property (@(posedge clk) disable iff (rst)
        32'(step_q) < seq_len(cmode, N_DAC + 2));

    assert_ctrl_rewinds_R12: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == DST_CTRL) |=> (step_q == '0));

    assert_test_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(commit && addr == DST_TEST) |=> $stable(test_q));

    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(commit && addr == DST_CTRL) |=> $stable(ctrl_q));

    assert_data_pad_R7: assert property (@(posedge clk) disable iff (rst)
        (!csel && rdsel == RS_DATA) |=> (tx_q[FRAME_W-1 -: (FRAME_W-RES_W)] == '0));

    assert_status_pad_R8: assert property (@(posedge clk) disable iff (rst)
        (!csel && rdsel == RS_STAT) |=>
            (tx_q[FRAME_W-2:RDSEL_LSB+2] == '0 && tx_q[RDSEL_LSB-1:CALSEL_LSB+2] == '0));

endmodule

bind adc_regfile adcreg_chk #(
    .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .RES_W(RES_W), .N_DAC(N_DAC)
) u_chk (
    .clk(clk), .rst(rst), .csel(csel), .commit(commit), .addr(addr),
    .ctrl_q(ctrl_q), .test_q(test_q), .step_q(step_q), .tx_q(tx_q),
    .rdsel(rdsel), .cmode(cmode)
);

// File: tb/tb_adc_regfile.sv
`timescale 1ns/1ps
module tb_adc_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csel = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [11:0] adc_data = '0;
    logic        busy = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [13:0] calv [10];

    adc_regfile dut (
        .clk(clk), .rst(rst), .csel(csel), .sdi(sdi), .sdo(sdo),
        .adc_data(adc_data), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full-duplex frame of nb bits; returns the first 16 bits seen on sdo.
    task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] rd);
        rd = '0;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            csel = 1'b1;
            sdi  = (i < 16) ? w[15-i] : 1'b1;
            #1;
            if (i < 16) rd[15-i] = sdo;
        end
        @(negedge clk);
        csel = 1'b0;
        sdi  = 1'b0;
        @(negedge clk);
    endtask

    task automatic ctrl(input logic [1:0] rs, input logic [1:0] cm);
        logic [15:0] d;
        xfer({2'b11, 6'b0, rs, 4'b0, cm}, 16, d);
    endtask

    task automatic wr(input logic [1:0] a, input logic [13:0] p);
        logic [15:0] d;
        xfer({a, p}, 16, d);
    endtask

    task automatic rd(output logic [15:0] d);
        xfer(16'h0000, 16, d);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        adc_data = 12'hABC;
        rd(d);      check("R1 data after reset", d, 16'h0ABC);
        ctrl(2'b01, 2'b00);
        rd(d);      check("R1 test after reset", d, 16'h0000);
        ctrl(2'b10, 2'b00);
        rd(d);      check("R1 gain after reset", d, 16'h0000);
        ctrl(2'b11, 2'b00);
        rd(d);      check("R1 status after reset", d, 16'h00C0);
    endtask

    task automatic t_data;
        logic [15:0] d;
        ctrl(2'b00, 2'b00);
        adc_data = 12'h5A5;
        rd(d);      check("R7 data 5A5", d, 16'h05A5);
        adc_data = 12'hFFF;
        rd(d);      check("R7 data FFF", d, 16'h0FFF);
        rd(d);      check("R6 select sticky", d, 16'h0FFF);
    endtask

    task automatic t_test;
        logic [15:0] d;
        ctrl(2'b01, 2'b00);
        wr(2'b01, 14'h2D3C);
        rd(d);      check("R5 R2 test 2D3C", d, 16'h2D3C);
        wr(2'b01, 14'h3FFF);
        rd(d);      check("R5 test 3FFF", d, 16'h3FFF);
    endtask

    task automatic t_early;
        logic [15:0] d;
        xfer({2'b01, 14'h0123}, 15, d);
        rd(d);      check("R3 test after short frame", d, 16'h3FFF);
        xfer({2'b11, 14'h0000}, 12, d);
        rd(d);      check("R3 ctrl after short frame", d, 16'h3FFF);
    endtask

    task automatic t_long;
        logic [15:0] d;
        xfer({2'b01, 14'h1111}, 20, d);
        rd(d);      check("R13 long frame", d, 16'h1111);
        check("R13 sdo MSB first", d, 16'h1111);
    endtask

    task automatic t_none;
        logic [15:0] d;
        wr(2'b00, 14'h3FFF);
        rd(d);      check("R4 null address keeps test", d, 16'h1111);
        wr(2'b00, 14'h0000);
        rd(d);      check("R4 null address keeps select", d, 16'h1111);
    endtask

    task automatic t_status;
        logic [15:0] d;
        busy = 1'b1;
        ctrl(2'b11, 2'b10);
        rd(d);      check("R8 status busy", d, 16'h80C2);
        busy = 1'b0;
        rd(d);      check("R8 status idle", d, 16'h00C2);
    endtask

    task automatic t_cal_all;
        logic [15:0] d;
        ctrl(2'b00, 2'b00);
        for (int k = 0; k < 10; k++) begin
            calv[k] = 14'(k * 14'h0155 + 14'h0021);
            wr(2'b10, calv[k]);
        end
        ctrl(2'b10, 2'b00);
        for (int k = 0; k < 10; k++) begin
            rd(d);  check("R9 walk all", d, {2'b00, calv[k]});
        end
        rd(d);      check("R9 wrap to gain", d, {2'b00, calv[0]});
    endtask

    task automatic t_pair;
        logic [15:0] d;
        ctrl(2'b10, 2'b01);
        rd(d);      check("R10 gain", d, {2'b00, calv[0]});
        rd(d);      check("R10 offset", d, {2'b00, calv[1]});
        rd(d);      check("R10 back to gain", d, {2'b00, calv[0]});
    endtask

    task automatic t_single;
        logic [15:0] d;
        ctrl(2'b10, 2'b10);
        rd(d);      check("R11 gain only a", d, {2'b00, calv[0]});
        rd(d);      check("R11 gain only b", d, {2'b00, calv[0]});
        ctrl(2'b10, 2'b11);
        rd(d);      check("R11 offset only a", d, {2'b00, calv[1]});
        rd(d);      check("R11 offset only b", d, {2'b00, calv[1]});
        ctrl(2'b00, 2'b11);
        wr(2'b10, 14'h2222);
        wr(2'b10, 14'h3333);
        calv[1] = 14'h3333;
        ctrl(2'b10, 2'b01);
        rd(d);      check("R11 gain untouched", d, {2'b00, calv[0]});
        rd(d);      check("R11 offset written", d, 16'h3333);
    endtask

    task automatic t_rewind;
        logic [15:0] d;
        ctrl(2'b10, 2'b00);
        for (int k = 0; k < 3; k++) begin
            rd(d);  check("R12 partial walk", d, {2'b00, calv[k]});
        end
        ctrl(2'b10, 2'b00);
        rd(d);      check("R12 rewound to gain", d, {2'b00, calv[0]});
        rd(d);      check("R12 then offset", d, {2'b00, calv[1]});
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_data();
        t_test();
        t_early();
        t_long();
        t_none();
        t_status();
        t_cal_all();
        t_pair();
        t_single();
        t_rewind();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule